// File: doc/BRIEF.md
# Horizontal line pulse generator

This block divides every television line into 32 equal slots of a master clock that runs at 32 times the line rate. A two-stage counter (a divide-by-2 prescaler that feeds a divide-by-16 stage) holds the slot position. The per-line pulses are decoded from that position: horizontal drive, horizontal clamp, horizontal processing blanking and the horizontal part of beam blanking. Each pulse edge falls on a whole slot, so every width is an exact small slot count. At a 504 kHz clock one slot is about 1.98 µs. At 500 kHz it is 2 µs.

A vertical sequencer sits beside this block. It reads the slot number, a line-start strobe and a half-line strobe, and uses them to place its own equalizing and serration events. External resynchronisation logic can restart the line at any time through a synchronous restart input.

The decode uses the next slot value and the result is registered. Because of this, in every cycle each output reflects the slot number shown on the `slot` port in that same cycle.

Top module: `hline_gen`

## Requirements
- R1: Outside reset and restart, `slot` advances by exactly one on each rising clock edge and wraps from 31 to 0, so a line lasts 32 clocks.
- R2: When `restart` is high at a rising edge, `slot` reads 0 after that edge and every pulse output takes its slot-0 value. Holding `restart` high keeps the line at slot 0.
- R3: While `rst` is high at a rising edge, the block goes to slot 0 with slot-0 output values: `hdrive`, `hblank`, `beam_blank` and `line_start` high, and `hclamp` and `half_line` low.
- R4: `hdrive` is high exactly when `slot` is 0 or 1, which gives 2 clocks per line.
- R5: `hclamp` is high exactly when `slot` is 2, which gives 1 clock per line. This slot lies after drive ends and inside processing blanking.
- R6: `hblank` is high exactly when `slot` is 0 through 5, which gives 6 clocks per line.
- R7: `beam_blank` is high exactly when `slot` is 0 through 3, which gives 4 clocks per line.
- R8: `line_start` is high only in slot 0 and `half_line` is high only in slot 16. Each strobe lasts one clock per line.
- R9: All outputs are registered and change only at a rising clock edge. In every cycle they agree with the `slot` value of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at 32 times line rate |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous active-high line restart |
| slot | output | 5 | Current slot within the line, 0 to 31 |
| hdrive | output | 1 | Horizontal drive pulse |
| hclamp | output | 1 | Horizontal clamp pulse |
| hblank | output | 1 | Horizontal processing blanking |
| beam_blank | output | 1 | Horizontal part of beam blanking |
| line_start | output | 1 | One-clock strobe in slot 0 |
| half_line | output | 1 | One-clock strobe in slot 16 |

## Verification
The bench tests restart in four places: in the middle of a line, on slot 31 where the counter would wrap by itself, held high for several clocks, and on slot 1 while drive is still high. A counter that ignored restart, or that let it act one edge late, would show a slot of 11 or 1 where 0 is expected. The bench also checks the carry from the prescaler into the divide-by-16 stage at every odd slot. A wrong carry would make slots skip or repeat, which moves `half_line` away from slot 16. Pulse widths are compared in every cycle, so decoding one slot too many or too few (for example `hblank` lasting 5 or 7 clocks) is caught in the cycle where it happens. A reset in the middle of a line checks that the register reset values match slot 0 and are not all low.

// File: rtl/hline_pkg.sv
package hline_pkg;

    // Line structure: prescaler followed by the main divider.
    parameter int unsigned PRE_DIV    = 2;
    parameter int unsigned MAIN_DIV   = 16;
    parameter int unsigned LINE_SLOTS = PRE_DIV * MAIN_DIV;
    parameter int unsigned SLOT_W     = $clog2(LINE_SLOTS);

    // Pulse placement, in slots.
    parameter int unsigned HD_SLOTS    = 2;
    parameter int unsigned CLAMP_SLOT  = 2;
    parameter int unsigned CLAMP_SLOTS = 1;
    parameter int unsigned PROC_SLOTS  = 6;
    parameter int unsigned BEAM_SLOTS  = 4;
    parameter int unsigned HALF_SLOT   = LINE_SLOTS / 2;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic hdrive;
        logic hclamp;
        logic hblank;
        logic beam;
        logic line_start;
        logic half_line;
    } hpulse_t;

    function automatic hpulse_t decode_slot(slot_t s);
        hpulse_t     p;
        int unsigned v;
        v            = 32'(s);
        p.hdrive     = (v < HD_SLOTS);
        p.hclamp     = (v >= CLAMP_SLOT) && (v < CLAMP_SLOT + CLAMP_SLOTS);
        p.hblank     = (v < PROC_SLOTS);
        p.beam       = (v < BEAM_SLOTS);
        p.line_start = (v == 0);
        p.half_line  = (v == HALF_SLOT);
        return p;
    endfunction

endpackage

// File: rtl/hline_div.sv
module hline_div
    import hline_pkg::*;
#(
    parameter int unsigned P_PRE  = PRE_DIV,
    parameter int unsigned P_MAIN = MAIN_DIV
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    output slot_t slot_nxt,
    output slot_t slot
);

    localparam int unsigned MAIN_W = $clog2(P_MAIN);

    logic [MAIN_W-1:0] main_q, main_d;
    logic              carry;
    logic              main_wrap;

    generate
        if (P_PRE > 1) begin : gen_pre
            localparam int unsigned PRE_W = $clog2(P_PRE);
            logic [PRE_W-1:0] pre_q, pre_d;
            logic             pre_wrap;

            assign pre_wrap = (pre_q == PRE_W'(P_PRE - 1));
            assign carry    = pre_wrap;

            always_comb begin
                if (restart || pre_wrap) pre_d = '0;
                else                     pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) pre_q <= '0;
                else     pre_q <= pre_d;
            end

            assign slot_nxt = {main_d, pre_d};
            assign slot     = {main_q, pre_q};
        end else begin : gen_nopre
            assign carry    = 1'b1;
            assign slot_nxt = main_d;
            assign slot     = main_q;
        end
    endgenerate

    assign main_wrap = (main_q == MAIN_W'(P_MAIN - 1));

    always_comb begin
        if (restart)        main_d = '0;
        else if (!carry)    main_d = main_q;
        else if (main_wrap) main_d = '0;
        else                main_d = main_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) main_q <= '0;
        else     main_q <= main_d;
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        !restart |=> slot == slot_t'($past(slot) + 1'b1)); // R1

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> slot == '0); // R2

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> slot == '0); // R3

endmodule

// File: rtl/hline_oreg.sv
module hline_oreg
    import hline_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  hpulse_t nxt,
    output hpulse_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= decode_slot('0);
        else     q <= nxt;
    end

    AST_HD_TWO: assert property (@(posedge clk) disable iff (rst)
        ($rose(q.hdrive) && !restart) |=> q.hdrive); // R4

    AST_CLAMP_PLACE: assert property (@(posedge clk) disable iff (rst)
        q.hclamp |-> (q.hblank && !q.hdrive)); // R5

    AST_BEAM_INSIDE: assert property (@(posedge clk) disable iff (rst)
        q.beam |-> q.hblank); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(q.line_start && q.half_line)); // R8

    AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        q.half_line |=> !q.half_line); // R8

endmodule

// File: rtl/hline_gen.sv
module hline_gen
    import hline_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [SLOT_W-1:0] slot,
    output logic             hdrive,
    output logic             hclamp,
    output logic             hblank,
    output logic             beam_blank,
    output logic             line_start,
    output logic             half_line
);

    slot_t   slot_nxt;
    slot_t   slot_cur;
    hpulse_t pulse_nxt;
    hpulse_t pulse_q;

    hline_div u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .slot_nxt (slot_nxt),
        .slot     (slot_cur)
    );

    assign pulse_nxt = decode_slot(slot_nxt);

    hline_oreg u_oreg (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .nxt     (pulse_nxt),
        .q       (pulse_q)
    );

    assign slot       = slot_cur;
    assign hdrive     = pulse_q.hdrive;
    assign hclamp     = pulse_q.hclamp;
    assign hblank     = pulse_q.hblank;
    assign beam_blank = pulse_q.beam;
    assign line_start = pulse_q.line_start;
    assign half_line  = pulse_q.half_line;

    AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
        line_start |-> slot_cur == '0); // R9

    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        half_line |-> slot_cur == slot_t'(HALF_SLOT)); // R9

endmodule

// File: tb/hline_gen_tb.sv
module hline_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restart = 1'b0;
    logic [4:0] slot;
    logic       hdrive, hclamp, hblank, beam_blank, line_start, half_line;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_slot = 0;
    string slot_tag = "R3";
    bit done = 1'b0;

    always #4 clk = ~clk;

    hline_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .slot       (slot),
        .hdrive     (hdrive),
        .hclamp     (hclamp),
        .hblank     (hblank),
        .beam_blank (beam_blank),
        .line_start (line_start),
        .half_line  (half_line)
    );

    // Behavioural reference: the line position as a plain integer.
    always @(posedge clk) begin
        if (rst) begin
            ref_slot = 0;
            slot_tag = "R3";
        end else if (restart) begin
            ref_slot = 0;
            slot_tag = "R2";
        end else begin
            ref_slot = (ref_slot + 1) % 32;
            slot_tag = "R1";
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (ref slot %0d)", req, what, act, exp, ref_slot);
        end
    endtask

    // Sample on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(slot_tag, "slot", int'(slot), ref_slot);
            chk("R4", "hdrive", int'(hdrive), (ref_slot <= 1) ? 1 : 0);
            chk("R5", "hclamp", int'(hclamp), (ref_slot == 2) ? 1 : 0);
            chk("R6", "hblank", int'(hblank), (ref_slot <= 5) ? 1 : 0);
            chk("R7", "beam_blank", int'(beam_blank), (ref_slot <= 3) ? 1 : 0);
            chk("R8", "line_start", int'(line_start), (ref_slot == 0) ? 1 : 0);
            chk("R8", "half_line", int'(half_line), (ref_slot == 16) ? 1 : 0);
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_slot(input int s);
        while (ref_slot != s) @(negedge clk);
    endtask

    initial begin
        run(3);                 // R3 reset state
        rst = 1'b0;
        run(80);                // R1 free running over wraps, R9 alignment
        wait_slot(10);
        restart = 1'b1; run(1); restart = 1'b0;   // R2 mid-line restart
        run(40);
        wait_slot(31);
        restart = 1'b1; run(1); restart = 1'b0;   // R2 restart on wrap slot
        run(20);
        restart = 1'b1; run(4); restart = 1'b0;   // R2 held restart
        run(1);
        restart = 1'b1; run(1); restart = 1'b0;   // R2 restart at slot 1
        run(40);
        wait_slot(20);
        rst = 1'b1; run(2); rst = 1'b0;           // R3 mid-line reset
        run(70);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule